// File: doc/BRIEF.md
# Asynchronous SRAM Pin Monitor

This block watches the pins of an asynchronous byte-wide static RAM and stands in for the memory itself. A fast verification clock samples the pins. The host side drives the chip-select, output-enable and write-enable strobes, a 15-bit address and the write data. The block holds a behavioural copy of the memory contents and returns read data under the same select rules as the real part. It also raises sticky flags when the strobes break the interface timing rules.

A write window is open while chip select and write enable are both low. The window closes on the first sample in which either strobe is high, whichever strobe rises first. At that sample the word seen on the last in-window sample is committed to the address seen on that sample.

Two state machines do the work:

- **Write machine.**
  - `WR_IDLE` to `WR_OPEN` when the window opens.
  - `WR_OPEN` to `WR_HOLD`, or back to `WR_IDLE`, when the window closes. The commit happens on this transition.
  - `WR_HOLD` to `WR_IDLE` when the hold interval has run out, or to `WR_OPEN` if a new window opens first.
- **Read machine.**
  - `RD_OFF` to `RD_ACCESS` on selection.
  - `RD_ACCESS` to `RD_VALID` when the access count has elapsed.
  - `RD_VALID` to `RD_ACCESS` on an address change.
  - Any state to `RD_OFF` when deselected.

All timing limits are parameters counted in clock ticks. The storage behind the 15-bit address is `2**MEM_AW` words, and the address bits above `MEM_AW` are folded away.

Top module: `sram_pin_monitor`

## Requirements
- R1: After reset, `bus_drive` and `bus_unknown` are 0, `bus_rdata` is 0, all four flags are 0 and `viol_count` is 0.
- R2: When a write window closes, the word on `bus_wdata` at the last in-window sample is stored at the address from that same sample. This holds whether chip select or write enable rises first. A later read of that address returns the word.
- R3: `bus_drive` is 1 one cycle after a sample with chip select low, output enable low and write enable high, and 0 after any other sample. This includes write enable falling before or together with chip select. `bus_rdata` is 0 whenever `bus_drive` is 0.
- R4: After the sample that selects a read, or the sample that changes the address of an ongoing read, `bus_unknown` is 1 and `bus_rdata` is 0 for `T_ACCESS` cycles. After that, `bus_unknown` is 0 and `bus_rdata` carries the stored word.
- R5: `flag_setup` is set when the committed word had been unchanged for fewer than `T_SETUP` consecutive samples when the window closed.
- R6: `flag_hold` is set when `bus_wdata` differs from the committed word within `T_HOLD` samples starting with the closing sample.
- R7: `flag_pulse` is set when the window lasted fewer than `T_PULSE` samples.
- R8: `flag_addr` is set when the address differs between two consecutive samples that both have write enable low.
- R9: Each flag stays set until its own clear input is sampled high. A violation in the same cycle as the clear leaves the flag set.
- R10: `viol_count` rises by the number of violations detected in a cycle and saturates at its maximum value.
- R11: Address bits at and above `MEM_AW` are ignored for storage. Addresses that agree in their low `MEM_AW` bits share one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Verification sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | input | ADDR_W | Address pins |
| mem_ce_n | input | 1 | Chip select, active low |
| mem_oe_n | input | 1 | Output enable, active low |
| mem_we_n | input | 1 | Write enable, active low |
| bus_wdata | input | DATA_W | Data driven onto the pins by the host |
| bus_rdata | output | DATA_W | Read data shown by the model (0 when not driving or unknown) |
| bus_drive | output | 1 | Model is driving the data pins (0 means high-Z) |
| bus_unknown | output | 1 | Driven data is not yet valid |
| clr_setup | input | 1 | Clears `flag_setup` |
| clr_hold | input | 1 | Clears `flag_hold` |
| clr_pulse | input | 1 | Clears `flag_pulse` |
| clr_addr | input | 1 | Clears `flag_addr` |
| flag_setup | output | 1 | Sticky data-setup violation |
| flag_hold | output | 1 | Sticky data-hold violation |
| flag_pulse | output | 1 | Sticky short write window |
| flag_addr | output | 1 | Sticky address change during write enable |
| viol_count | output | ERR_W | Saturating count of violations |

## Verification
The hardest cases to reach are the ones where a violation must be raised on its own, without tripping the others. A short write window normally also looks like a setup failure, because the data usually changes when the window opens. The stimulus therefore presets the data several idle cycles before opening a two-sample window, so only the pulse rule can fire. The setup case keeps the window long and changes the data two samples before the close. The hold case changes the data on exactly the closing sample. Saturation of the counter is reached by a burst of one-sample windows that each add two violations.

// File: rtl/sram_mon_pkg.sv
package sram_mon_pkg;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_OPEN = 2'd1,
        WR_HOLD = 2'd2
    } wr_state_t;

    typedef enum logic [1:0] {
        RD_OFF    = 2'd0,
        RD_ACCESS = 2'd1,
        RD_VALID  = 2'd2
    } rd_state_t;

    // one bit per timing rule
    typedef struct packed {
        logic setup;
        logic hold;
        logic pulse;
        logic addr;
    } viol_t;

endpackage

// File: rtl/sram_mon_wr_fsm.sv
module sram_mon_wr_fsm
    import sram_mon_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 8,
    parameter int T_SETUP = 4,
    parameter int T_HOLD  = 1,
    parameter int T_PULSE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] din,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output viol_t             viol
);

    localparam logic [CNT_W-1:0] SETUP_LIM   = CNT_W'(T_SETUP);
    localparam logic [CNT_W-1:0] PULSE_LIM   = CNT_W'(T_PULSE);
    localparam logic [CNT_W-1:0] HOLD_RELOAD = CNT_W'((T_HOLD > 1) ? T_HOLD - 1 : 0);
    localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX     = '1;
    localparam bit               HOLD_ON     = (T_HOLD > 0);
    localparam bit               HOLD_STATE  = (T_HOLD > 1);

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + ONE;
    endfunction

    wr_state_t         state, state_nxt;
    logic              win;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] din_q;
    logic [DATA_W-1:0] hold_val;
    logic              we_q;
    logic [CNT_W-1:0]  run_len;
    logic [CNT_W-1:0]  pulse_len;
    logic [CNT_W-1:0]  hold_left;

    assign win = !ce_n && !we_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= state_nxt;
    end

    // next state and commit strobe
    always_comb begin
        state_nxt = state;
        commit    = 1'b0;
        unique case (state)
            WR_IDLE: begin
                if (win) state_nxt = WR_OPEN;
            end
            WR_OPEN: begin
                if (!win) begin
                    commit    = 1'b1;
                    state_nxt = HOLD_STATE ? WR_HOLD : WR_IDLE;
                end
            end
            WR_HOLD: begin
                if (win)                    state_nxt = WR_OPEN;
                else if (hold_left <= ONE)  state_nxt = WR_IDLE;
            end
            default: state_nxt = WR_IDLE;
        endcase
    end

    // sampled pins and interval counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            din_q     <= '0;
            we_q      <= 1'b1;
            run_len   <= '0;
            pulse_len <= '0;
            hold_left <= '0;
            hold_val  <= '0;
        end else begin
            addr_q  <= addr;
            din_q   <= din;
            we_q    <= we_n;
            run_len <= (din != din_q) ? ONE : sat_inc(run_len);
            if (win)
                pulse_len <= (state == WR_OPEN) ? sat_inc(pulse_len) : ONE;
            else
                pulse_len <= '0;
            if (commit) begin
                hold_left <= HOLD_RELOAD;
                hold_val  <= din_q;
            end else if (state == WR_HOLD && hold_left != '0) begin
                hold_left <= hold_left - ONE;
            end
        end
    end

    assign commit_addr = addr_q;
    assign commit_data = din_q;

    always_comb begin
        viol.setup = commit && (run_len < SETUP_LIM);
        viol.pulse = commit && (pulse_len < PULSE_LIM);
        viol.hold  = (commit && HOLD_ON && (din != din_q)) ||
                     ((state == WR_HOLD) && !win && (din != hold_val));
        viol.addr  = !we_n && !we_q && (addr != addr_q);
    end

    // R2: a commit only follows a sample in which the window was open
    p_commit_after_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(win));

    // R7: an open window never lasts into a commit without being counted
    p_open_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_OPEN && win) |=> (pulse_len >= 2 || pulse_len == CNT_MAX));

    // R6: the hold interval is entered only right after a commit
    p_hold_after_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_HOLD && $past(state) != WR_HOLD) |-> $past(commit));

endmodule

// File: rtl/sram_mon_rd_fsm.sv
module sram_mon_rd_fsm
    import sram_mon_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int CNT_W    = 8,
    parameter int T_ACCESS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic              drive_en,
    output logic              unknown,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam logic [CNT_W-1:0] ACC_LIM = CNT_W'(T_ACCESS);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    rd_state_t         state, state_nxt;
    logic              sel;
    logic              addr_chg;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  acc_cnt, acc_nxt;

    assign sel      = !ce_n && !oe_n && we_n;
    assign addr_chg = (addr != addr_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RD_OFF;
            acc_cnt <= '0;
            addr_q  <= '0;
        end else begin
            state   <= state_nxt;
            acc_cnt <= acc_nxt;
            addr_q  <= addr;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        acc_nxt   = '0;
        if (!sel) begin
            state_nxt = RD_OFF;
        end else begin
            unique case (state)
                RD_OFF: begin
                    state_nxt = RD_ACCESS;
                    acc_nxt   = ONE;
                end
                RD_ACCESS: begin
                    if (addr_chg) begin
                        acc_nxt = ONE;
                    end else if (acc_cnt >= ACC_LIM) begin
                        state_nxt = RD_VALID;
                    end else begin
                        acc_nxt = acc_cnt + ONE;
                    end
                end
                RD_VALID: begin
                    if (addr_chg) begin
                        state_nxt = RD_ACCESS;
                        acc_nxt   = ONE;
                    end
                end
                default: state_nxt = RD_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        drive_en = (state != RD_OFF);
        unknown  = (state == RD_ACCESS);
        rd_addr  = addr_q;
    end

    // R3: write enable low on the pins forces the read side off next cycle
    p_off_when_writing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> (state == RD_OFF));

    // R4: valid data is only reached through the access interval
    p_valid_via_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_VALID && $past(state) != RD_VALID) |-> ($past(state) == RD_ACCESS));

endmodule

// File: rtl/sram_mon_store.sv
module sram_mon_store #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int MEM_AW = 11
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [MEM_AW-1:0] wa, ra;

    assign wa = waddr[MEM_AW-1:0];
    assign ra = raddr[MEM_AW-1:0];

    generate
        if (MEM_AW < ADDR_W) begin : g_fold
            logic unused_hi;
            assign unused_hi = ^{waddr[ADDR_W-1:MEM_AW], raddr[ADDR_W-1:MEM_AW]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en) mem[wa] <= wdata;
    end

    assign rdata = mem[ra];

endmodule

// File: rtl/sram_mon_errors.sv
module sram_mon_errors
    import sram_mon_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  viol_t            viol,
    input  viol_t            clr,
    output viol_t            flags,
    output logic [ERR_W-1:0] count
);

    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    logic [3:0]       v_v, c_v, f_v;
    logic [2:0]       inc;
    logic [ERR_W:0]   sum;

    assign v_v = viol;
    assign c_v = clr;
    assign f_v = flags;
    assign inc = 3'(v_v[0]) + 3'(v_v[1]) + 3'(v_v[2]) + 3'(v_v[3]);
    assign sum = {1'b0, count} + (ERR_W + 1)'(inc);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            count <= '0;
        end else begin
            flags <= viol_t'(v_v | (f_v & ~c_v));
            count <= sum[ERR_W] ? CNT_MAX : sum[ERR_W-1:0];
        end
    end

    // R9: an uncleared flag stays set
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((f_v & ~c_v) != 4'b0) |=> ((f_v & $past(f_v & ~c_v)) == $past(f_v & ~c_v)));

    // R10: a full counter stays full
    p_count_saturates_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX));

    // R10: any violation moves a counter that has room
    p_count_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((v_v != 4'b0) && count != CNT_MAX) |=> (count != $past(count)));

endmodule

// File: rtl/sram_pin_monitor.sv
module sram_pin_monitor
    import sram_mon_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int MEM_AW   = 11,
    parameter int CNT_W    = 8,
    parameter int T_SETUP  = 4,
    parameter int T_HOLD   = 1,
    parameter int T_PULSE  = 6,
    parameter int T_ACCESS = 7,
    parameter int ERR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ce_n,
    input  logic              mem_oe_n,
    input  logic              mem_we_n,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_drive,
    output logic              bus_unknown,
    input  logic              clr_setup,
    input  logic              clr_hold,
    input  logic              clr_pulse,
    input  logic              clr_addr,
    output logic              flag_setup,
    output logic              flag_hold,
    output logic              flag_pulse,
    output logic              flag_addr,
    output logic [ERR_W-1:0]  viol_count
);

    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] mem_word;
    viol_t             viol, clr, flags;

    sram_mon_wr_fsm #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CNT_W (CNT_W),
        .T_SETUP(T_SETUP), .T_HOLD(T_HOLD), .T_PULSE(T_PULSE)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (mem_addr),
        .ce_n       (mem_ce_n),
        .we_n       (mem_we_n),
        .din        (bus_wdata),
        .commit     (commit),
        .commit_addr(commit_addr),
        .commit_data(commit_data),
        .viol       (viol)
    );

    sram_mon_rd_fsm #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .T_ACCESS(T_ACCESS)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (mem_addr),
        .ce_n    (mem_ce_n),
        .oe_n    (mem_oe_n),
        .we_n    (mem_we_n),
        .drive_en(bus_drive),
        .unknown (bus_unknown),
        .rd_addr (rd_addr)
    );

    sram_mon_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW)
    ) u_store (
        .clk  (clk),
        .wr_en(commit),
        .waddr(commit_addr),
        .wdata(commit_data),
        .raddr(rd_addr),
        .rdata(mem_word)
    );

    assign clr = '{setup: clr_setup, hold: clr_hold, pulse: clr_pulse, addr: clr_addr};

    sram_mon_errors #(
        .ERR_W(ERR_W)
    ) u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .viol (viol),
        .clr  (clr),
        .flags(flags),
        .count(viol_count)
    );

    assign flag_setup = flags.setup;
    assign flag_hold  = flags.hold;
    assign flag_pulse = flags.pulse;
    assign flag_addr  = flags.addr;
    assign bus_rdata  = (bus_drive && !bus_unknown) ? mem_word : '0;

    // R3: no data leaves the model while write enable was low
    p_hiz_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> (!bus_drive && bus_rdata == '0));

    // R4: data is never shown while it is still unknown
    p_no_data_when_unknown_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_unknown |-> (bus_rdata == '0));

endmodule

// File: tb/sram_pin_monitor_bench.sv
module sram_pin_monitor_bench;

    localparam int AW = 15, DW = 8, MAW = 11;
    localparam int TS = 4, TH = 1, TP = 6, TA = 7, EW = 8;
    localparam int EMAX = (1 << EW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_n, oe_n, we_n;
    logic [DW-1:0] wdata, rdata;
    logic          drive, unknown;
    logic          c_setup, c_hold, c_pulse, c_addr;
    logic          f_setup, f_hold, f_pulse, f_addr;
    logic [EW-1:0] vcount;

    always #5 clk = ~clk;

    sram_pin_monitor #(
        .ADDR_W(AW), .DATA_W(DW), .MEM_AW(MAW), .CNT_W(8),
        .T_SETUP(TS), .T_HOLD(TH), .T_PULSE(TP), .T_ACCESS(TA), .ERR_W(EW)
    ) u_sram_pin_monitor (
        .clk(clk), .rst_n(rst_n), .mem_addr(addr), .mem_ce_n(ce_n),
        .mem_oe_n(oe_n), .mem_we_n(we_n), .bus_wdata(wdata),
        .bus_rdata(rdata), .bus_drive(drive), .bus_unknown(unknown),
        .clr_setup(c_setup), .clr_hold(c_hold), .clr_pulse(c_pulse),
        .clr_addr(c_addr), .flag_setup(f_setup), .flag_hold(f_hold),
        .flag_pulse(f_pulse), .flag_addr(f_addr), .viol_count(vcount)
    );

    int checks = 0;
    int failures = 0;
    int exp_cnt = 0;
    bit done = 0;
    logic [DW-1:0] ref_mem [1 << MAW];
    logic [AW-1:0] wlist [256];
    int nwr = 0;

    function automatic logic [MAW-1:0] fold(input logic [AW-1:0] a);
        return a[MAW-1:0];
    endfunction

    function automatic int sat_add(input int c, input int n);
        return (c + n > EMAX) ? EMAX : c + n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag, input logic [3:0] exp);
        chk(tag, {28'd0, f_setup, f_hold, f_pulse, f_addr}, {28'd0, exp});
    endtask

    task automatic go_idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    // clean write: 7 window samples, data set with the window
    task automatic wr_good(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit by_ce);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        repeat (7) @(negedge clk);
        if (by_ce) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk);
        go_idle();
        @(negedge clk);
        ref_mem[fold(a)] = d;
        wlist[nwr % 256] = a;
        nwr++;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        chk({tag, " R3 drive"}, {31'd0, drive}, 32'd1);
        chk({tag, " R4 unknown first"}, {31'd0, unknown}, 32'd1);
        repeat (TA - 1) @(negedge clk);
        chk({tag, " R4 unknown last"}, {31'd0, unknown}, 32'd1);
        chk({tag, " R4 data hidden"}, {24'd0, rdata}, 32'd0);
        @(negedge clk);
        chk({tag, " R4 valid"}, {31'd0, unknown}, 32'd0);
        chk({tag, " R2 data"}, {24'd0, rdata}, {24'd0, ref_mem[fold(a)]});
        go_idle();
        @(negedge clk);
    endtask

    // two-sample window with data preset long before: only the pulse rule fires
    task automatic short_window(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit clr_at_close);
        @(negedge clk);
        addr = a; wdata = d;
        repeat (5) @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        go_idle();
        if (clr_at_close) c_pulse = 1'b1;
        @(negedge clk);
        c_pulse = 1'b0;
        @(negedge clk);
        ref_mem[fold(a)] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        rst_n = 1'b0; addr = '0; wdata = '0;
        c_setup = 0; c_hold = 0; c_pulse = 0; c_addr = 0;
        go_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 drive", {31'd0, drive}, 32'd0);
        chk("R1 unknown", {31'd0, unknown}, 32'd0);
        chk("R1 rdata", {24'd0, rdata}, 32'd0);
        chk_flags("R1 flags", 4'b0000);
        chk("R1 count", {24'd0, vcount}, 32'd0);

        // R2 write closed by write enable, then by chip select
        wr_good(15'h0123, 8'hA5, 1'b0);
        rd_chk(15'h0123, "we-closed");
        wr_good(15'h0456, 8'h3C, 1'b1);
        rd_chk(15'h0456, "ce-closed");

        // R3 write enable low before chip select: outputs stay off
        @(negedge clk);
        addr = 15'h0100; wdata = 8'h77; oe_n = 1'b0; we_n = 1'b0; ce_n = 1'b1;
        @(negedge clk);
        chk("R3 we first, ce high", {31'd0, drive}, 32'd0);
        ce_n = 1'b0;
        @(negedge clk);
        chk("R3 we first, ce low", {31'd0, drive}, 32'd0);
        repeat (6) @(negedge clk);
        chk("R3 during write", {31'd0, drive}, 32'd0);
        we_n = 1'b1;
        @(negedge clk);
        go_idle();
        @(negedge clk);
        ref_mem[fold(15'h0100)] = 8'h77;
        rd_chk(15'h0100, "we-first");
        // R3 output enable high keeps high-Z
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        chk("R3 oe high", {31'd0, drive}, 32'd0);
        chk("R3 oe high rdata", {24'd0, rdata}, 32'd0);
        go_idle();
        chk_flags("R2 clean writes no flags", 4'b0000);

        // R5 setup: data changes two samples before close
        @(negedge clk);
        addr = 15'h0200; wdata = 8'h11; ce_n = 1'b0; we_n = 1'b0;
        repeat (5) @(negedge clk);
        wdata = 8'h22;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        go_idle();
        @(negedge clk);
        ref_mem[fold(15'h0200)] = 8'h22;
        exp_cnt = sat_add(exp_cnt, 1);
        chk_flags("R5 setup flag", 4'b1000);
        chk("R10 count after setup", {24'd0, vcount}, exp_cnt);
        rd_chk(15'h0200, "setup");

        // R9 clear of the setup flag
        @(negedge clk);
        c_setup = 1'b1;
        @(negedge clk);
        c_setup = 1'b0;
        @(negedge clk);
        chk_flags("R9 setup cleared", 4'b0000);
        chk("R9 count kept", {24'd0, vcount}, exp_cnt);

        // R6 hold: data changes on the closing sample
        @(negedge clk);
        addr = 15'h0210; wdata = 8'h44; ce_n = 1'b0; we_n = 1'b0;
        repeat (7) @(negedge clk);
        we_n = 1'b1; wdata = 8'h99;
        @(negedge clk);
        go_idle();
        @(negedge clk);
        ref_mem[fold(15'h0210)] = 8'h44;
        exp_cnt = sat_add(exp_cnt, 1);
        chk_flags("R6 hold flag", 4'b0100);
        chk("R10 count after hold", {24'd0, vcount}, exp_cnt);
        rd_chk(15'h0210, "hold");

        // R7 short window
        short_window(15'h0220, 8'h55, 1'b0);
        exp_cnt = sat_add(exp_cnt, 1);
        chk_flags("R7 pulse flag", 4'b0110);
        chk("R10 count after pulse", {24'd0, vcount}, exp_cnt);

        // R8 address moves while write enable is low
        @(negedge clk);
        addr = 15'h0230; wdata = 8'h66; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        addr = 15'h0231;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        go_idle();
        @(negedge clk);
        ref_mem[fold(15'h0231)] = 8'h66;
        exp_cnt = sat_add(exp_cnt, 1);
        chk_flags("R8 addr flag", 4'b0111);
        chk("R10 count after addr", {24'd0, vcount}, exp_cnt);

        // R9 violation in the same cycle as its clear: flag stays
        short_window(15'h0240, 8'h5A, 1'b1);
        exp_cnt = sat_add(exp_cnt, 1);
        chk_flags("R9 set beats clear", 4'b0111);
        @(negedge clk);
        c_setup = 1; c_hold = 1; c_pulse = 1; c_addr = 1;
        @(negedge clk);
        c_setup = 0; c_hold = 0; c_pulse = 0; c_addr = 0;
        @(negedge clk);
        chk_flags("R9 all cleared", 4'b0000);
        chk("R10 count after clears", {24'd0, vcount}, exp_cnt);

        // R11 upper address bits fold onto the same word
        wr_good(15'h0805, 8'hC3, 1'b0);
        rd_chk(15'h0005, "R11 alias low");
        rd_chk(15'h7805, "R11 alias high");

        // R4 address change during an ongoing read
        @(negedge clk);
        addr = 15'h0123; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (TA + 1) @(negedge clk);
        chk("R4 first word", {24'd0, rdata}, {24'd0, ref_mem[fold(15'h0123)]});
        addr = 15'h0456;
        @(negedge clk);
        chk("R4 unknown after change", {31'd0, unknown}, 32'd1);
        repeat (TA - 1) @(negedge clk);
        chk("R4 still unknown", {31'd0, unknown}, 32'd1);
        @(negedge clk);
        chk("R4 second word", {24'd0, rdata}, {24'd0, ref_mem[fold(15'h0456)]});
        go_idle();
        @(negedge clk);

        // random clean traffic
        for (int i = 0; i < 120; i++) begin
            if (nwr == 0 || ($urandom % 2) == 0) begin
                logic [31:0] r;
                r = $urandom;
                wr_good(r[AW-1:0], r[AW+DW-1:AW], r[31]);
            end else begin
                int lim;
                lim = (nwr > 256) ? 256 : nwr;
                rd_chk(wlist[$urandom % lim], "R2 random");
            end
        end
        chk_flags("R5 R6 R7 R8 no flags from clean traffic", 4'b0000);
        chk("R10 count steady", {24'd0, vcount}, exp_cnt);

        // R10 saturation: one-sample windows add setup and pulse each
        for (int i = 0; i < 130; i++) begin
            @(negedge clk);
            addr = 15'h0300; wdata = DW'(i + 1); ce_n = 1'b0; we_n = 1'b0;
            @(negedge clk);
            go_idle();
            @(negedge clk);
            exp_cnt = sat_add(exp_cnt, 2);
        end
        @(negedge clk);
        chk("R10 saturated count", {24'd0, vcount}, exp_cnt);
        chk_flags("R10 flags after burst", 4'b1010);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule